// File: doc/BRIEF.md
# Converter Host Bus Interface

This block sits between a processor bus and an analog-to-digital converter core, so that the converter appears to software as one memory or I/O location. The host drives active-low chip select, read and write strobes and a mode pin. The block turns these into one-cycle start requests for the core. It captures the core's result when the core signals completion, or earlier if the host asks for it. It then presents the result on an 8-bit bus, which is modelled as a data word plus an output enable. An active-low interrupt and a ready flag tell the host when a result is available.

With the mode pin low, a read access starts the conversion. If the host holds the read until the interrupt falls, it sees the new result. If it releases the read early, it has made a pipelined read: the bus showed the previous result, and the new one is kept for the next access. With the mode pin high, the rising edge of the write strobe starts the conversion. A read issued during the conversion ends it at once with the core's current word. Chip select and read may also be held low permanently, so that only the write strobe paces conversions. All converter timing is expressed in clock cycles, and the host pins are sampled on the block clock.

Top module: `adc_host_if`

## Requirements
- R1: After reset, intN and rdy are high, dataOe is low and startReq is low.
- R2: With mode low and no conversion in progress, the first cycle in which csN and rdN are both low (after a cycle in which they were not) produces a startReq pulse exactly one cycle long, beginning on the next cycle.
- R3: A coreDone pulse during a conversion stores coreData as the result and drives intN low on the next cycle. A host still holding the read sees that result on dataOut with dataOe high.
- R4: rdy goes low on the cycle after a read-mode start and returns high on the cycle after the result is captured.
- R5: dataOe is high only while csN and rdN are both low and a result has been captured since reset. dataOut then carries the most recently captured result.
- R6: A read-mode access that is released before completion still starts a conversion, and during it the bus shows the previous result.
- R7: With mode high, a rising edge of wrN seen while csN is low starts a conversion.
- R8: With mode high, a new read access during a conversion ends it at once. It captures the present coreData and drives intN low on the next cycle.
- R9: With csN and rdN held low in write mode, each wrN rising edge starts a conversion, and the new result appears on the bus once the core completes.
- R10: intN returns high on the cycle after a new read access or a conversion start, unless a capture happens in the same cycle.
- R11: A read-mode start is ignored until GAP_CYCLES cycles have passed since csN last rose.
- R12: A start request made during a conversion is ignored. So is a coreDone pulse that arrives after the conversion has already ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low; its rising edge starts a conversion in write mode |
| mode | input | 1 | 0 = read-initiated conversion, 1 = write-initiated conversion |
| intN | output | 1 | End-of-conversion interrupt, active low |
| rdy | output | 1 | Low while a read-mode conversion is in progress |
| dataOut | output | DATA_W | Result word presented to the host |
| dataOe | output | 1 | Output enable for the host data bus (low = high impedance) |
| startReq | output | 1 | One-cycle start pulse to the converter core |
| coreDone | input | 1 | One-cycle completion pulse from the core |
| coreData | input | DATA_W | Conversion word from the core |

## Verification
A busy flag that is stuck high blocks every later start, so startReq stays silent and intN never falls within the conversion time. A busy flag that is stuck low lets a second write edge or an overlapping read produce an extra startReq pulse one cycle after the strobe. A wrong result register or valid flag shows on the next read access, as the wrong word or as an enable that rises too early. A gap counter that is loaded wrongly shows as a startReq pulse right after chip select is asserted again, or as no pulse once the gap has passed.

// File: rtl/adc_host_if_pkg.sv
package adc_host_if_pkg;
  // Strobes from the control to the datapath.
  typedef struct packed {
    logic capture;  // latch coreData as the new result, assert interrupt
    logic clrInt;   // release the interrupt
  } hostStrobe_t;
endpackage

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
  import adc_host_if_pkg::*;
#(
  parameter int GAP_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        rdN,
  input  logic        wrN,
  input  logic        mode,
  input  logic        coreDone,
  output logic        startReq,
  output logic        rdy,
  output hostStrobe_t stb
);
  localparam int GW = (GAP_CYCLES > 0) ? $clog2(GAP_CYCLES + 1) : 1;

  logic accNow, accPrev, wrPrev, csPrev;
  logic accFall, wrRise, csRise;
  logic busyQ, gapOk;
  logic rdStart, wrStart, doStart, earlyRd, doneCap;
  logic [GW-1:0] gapCnt;

  assign accNow  = !csN && !rdN;
  assign accFall = accNow && !accPrev;
  assign wrRise  = wrN && !wrPrev && !csN;
  assign csRise  = csN && !csPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accPrev <= 1'b0;
      wrPrev  <= 1'b1;
      csPrev  <= 1'b1;
    end else begin
      accPrev <= accNow;
      wrPrev  <= wrN;
      csPrev  <= csN;
    end
  end

  // Gap between chip-select release and the next read-initiated start.
  generate
    if (GAP_CYCLES == 0) begin : g_noGap
      assign gapCnt = '0;
      assign gapOk  = 1'b1;
    end else begin : g_gap
      logic [GW-1:0] gapQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              gapQ <= '0;
        else if (csRise)        gapQ <= GW'(GAP_CYCLES);
        else if (gapQ != '0)    gapQ <= gapQ - 1'b1;
      end
      assign gapCnt = gapQ;
      assign gapOk  = (gapQ == '0);
    end
  endgenerate

  assign rdStart = !mode && accFall && gapOk && !busyQ;
  assign wrStart = mode && wrRise && !busyQ;
  assign doStart = rdStart || wrStart;
  assign earlyRd = mode && accFall && busyQ;
  assign doneCap = coreDone && busyQ;

  always_comb begin
    stb.capture = doneCap || earlyRd;
    stb.clrInt  = accFall || doStart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      startReq <= 1'b0;
      rdy      <= 1'b1;
    end else begin
      startReq <= doStart;
      if (stb.capture)  busyQ <= 1'b0;
      else if (doStart) busyQ <= 1'b1;
      if (rdStart)          rdy <= 1'b0;
      else if (stb.capture) rdy <= 1'b1;
    end
  end

  // R12
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !stb.capture) |=> !startReq);
  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> !startReq);
  // R4
  rdy_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdy |-> busyQ);
  // R11
  gap_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !$past(mode)) |-> ($past(gapCnt) == '0));
endmodule

// File: rtl/adc_host_dp.sv
module adc_host_dp
  import adc_host_if_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  hostStrobe_t       stb,
  input  logic [DATA_W-1:0] coreData,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              intN
);
  logic [DATA_W-1:0] resultQ;
  logic              validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      validQ  <= 1'b0;
      intN    <= 1'b1;
    end else begin
      if (stb.capture) begin
        resultQ <= coreData;
        validQ  <= 1'b1;
      end
      if (stb.capture)     intN <= 1'b0;
      else if (stb.clrInt) intN <= 1'b1;
    end
  end

  assign dataOe  = !csN && !rdN && validQ;
  assign dataOut = dataOe ? resultQ : '0;

  // R3
  int_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> !intN);
  // R10
  int_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrInt && !stb.capture) |=> intN);
  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.capture |=> $stable(resultQ));
endmodule

// File: rtl/adc_host_if.sv
module adc_host_if
  import adc_host_if_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int GAP_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              mode,
  output logic              intN,
  output logic              rdy,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              startReq,
  input  logic              coreDone,
  input  logic [DATA_W-1:0] coreData
);
  hostStrobe_t stb;

  adc_host_ctrl #(.GAP_CYCLES(GAP_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN), .mode(mode),
    .coreDone(coreDone), .startReq(startReq), .rdy(rdy), .stb(stb)
  );

  adc_host_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .stb(stb),
    .coreData(coreData), .dataOut(dataOut), .dataOe(dataOe), .intN(intN)
  );
endmodule

// File: tb/tb_adc_host_if.sv
module tb_adc_host_if;
  localparam int CONV = 8;
  localparam int GAP  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rdN = 1'b1, wrN = 1'b1, mode = 1'b0;
  logic intN, rdy, dataOe, startReq, coreDone;
  logic [7:0] dataOut;
  logic [7:0] coreData = 8'h00;
  int checks = 0, errors = 0, startCnt = 0, cyc = 0, convCnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_host_if #(.DATA_W(8), .GAP_CYCLES(GAP)) dut (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN), .mode(mode),
    .intN(intN), .rdy(rdy), .dataOut(dataOut), .dataOe(dataOe),
    .startReq(startReq), .coreDone(coreDone), .coreData(coreData)
  );

  // Core model: completes CONV cycles after it sees a start pulse.
  always @(posedge clk) begin
    if (startReq) convCnt <= CONV;
    else if (convCnt != 0) convCnt <= convCnt - 1;
    if (startReq) startCnt <= startCnt + 1;
  end
  assign coreDone = (convCnt == 1);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000 && !finished) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitInt(string req);
    int n = 0;
    while (intN !== 1'b0 && n < 60) begin tick(1); n++; end
    chk(req, {31'd0, intN}, 32'd0);
  endtask

  task automatic releaseBus();
    csN = 1'b1; rdN = 1'b1; wrN = 1'b1;
    tick(GAP + 3);
  endtask

  task automatic testReset();
    chk("R1 intN", {31'd0, intN}, 1);
    chk("R1 rdy", {31'd0, rdy}, 1);
    chk("R1 dataOe", {31'd0, dataOe}, 0);
    chk("R1 startReq", {31'd0, startReq}, 0);
  endtask

  task automatic testReadMode();
    mode = 1'b0; coreData = 8'h5A;
    csN = 1'b0; rdN = 1'b0;
    #1 chk("R5 no result yet", {31'd0, dataOe}, 0);
    tick(1);
    chk("R2 start pulse", {31'd0, startReq}, 1);
    chk("R4 rdy low", {31'd0, rdy}, 0);
    tick(1);
    chk("R2 pulse one cycle", {31'd0, startReq}, 0);
    waitInt("R3 intN falls");
    chk("R3 oe", {31'd0, dataOe}, 1);
    chk("R3 data", {24'd0, dataOut}, 32'h5A);
    chk("R4 rdy high", {31'd0, rdy}, 1);
    csN = 1'b1; rdN = 1'b1;
    #1 chk("R5 released", {31'd0, dataOe}, 0);
    tick(GAP + 3);
  endtask

  task automatic testIntClear();
    mode = 1'b1;
    csN = 1'b0; rdN = 1'b0;
    tick(1);
    chk("R10 read clears int", {31'd0, intN}, 1);
    chk("R5 held result", {24'd0, dataOut}, 32'h5A);
    releaseBus();
  endtask

  task automatic testPipelined();
    int s0;
    mode = 1'b0; coreData = 8'hC3; s0 = startCnt;
    csN = 1'b0; rdN = 1'b0;
    #1 chk("R6 previous word", {24'd0, dataOut}, 32'h5A);
    tick(2);
    csN = 1'b1; rdN = 1'b1;
    waitInt("R6 first done");
    chk("R6 started", startCnt, s0 + 1);
    tick(GAP + 3);
    coreData = 8'h11;
    csN = 1'b0; rdN = 1'b0;
    #1 chk("R6 second pulse word", {24'd0, dataOut}, 32'hC3);
    tick(2);
    csN = 1'b1; rdN = 1'b1;
    waitInt("R6 second done");
    chk("R6 second start", startCnt, s0 + 2);
    tick(GAP + 3);
  endtask

  task automatic testGap();
    int s0;
    mode = 1'b0; s0 = startCnt;
    csN = 1'b0; tick(1);
    csN = 1'b1; tick(1);
    csN = 1'b0; rdN = 1'b0; tick(3);
    chk("R11 start inside gap ignored", startCnt, s0);
    csN = 1'b1; rdN = 1'b1; tick(GAP + 3);
    csN = 1'b0; rdN = 1'b0; tick(2);
    chk("R11 start after gap", startCnt, s0 + 1);
    waitInt("R11 done");
    releaseBus();
  endtask

  task automatic testWriteMode();
    int s0;
    mode = 1'b1; coreData = 8'h96; s0 = startCnt;
    csN = 1'b0; wrN = 1'b0; tick(1);
    wrN = 1'b1; tick(1);
    chk("R7 write start", {31'd0, startReq}, 1);
    chk("R10 start clears int", {31'd0, intN}, 1);
    wrN = 1'b0; tick(1);
    wrN = 1'b1; tick(2);
    chk("R12 busy start ignored", startCnt, s0 + 1);
    waitInt("R7 done");
    rdN = 1'b0;
    #1 chk("R7 data", {24'd0, dataOut}, 32'h96);
    releaseBus();
  endtask

  task automatic testEarlyRead();
    mode = 1'b1; coreData = 8'h3C;
    csN = 1'b0; wrN = 1'b0; tick(1);
    wrN = 1'b1; tick(3);
    rdN = 1'b0; tick(1);
    chk("R8 int at once", {31'd0, intN}, 0);
    chk("R8 data", {24'd0, dataOut}, 32'h3C);
    coreData = 8'hE7;
    csN = 1'b1; rdN = 1'b1;
    tick(CONV + 4);
    csN = 1'b0; rdN = 1'b0;
    #1 chk("R12 late done ignored", {24'd0, dataOut}, 32'h3C);
    releaseBus();
  endtask

  task automatic testTiedLow();
    mode = 1'b1; coreData = 8'h42;
    csN = 1'b0; rdN = 1'b0; tick(2);
    wrN = 1'b0; tick(1);
    wrN = 1'b1; tick(2);
    chk("R9 old word during conversion", {24'd0, dataOut}, 32'h3C);
    waitInt("R9 done");
    chk("R9 new word", {24'd0, dataOut}, 32'h42);
    chk("R9 oe", {31'd0, dataOe}, 1);
    releaseBus();
  endtask

  initial begin
    tick(3);
    testReset();
    rstN = 1'b1;
    tick(2);
    testReset();
    testReadMode();
    testIntClear();
    testPipelined();
    testGap();
    testWriteMode();
    testEarlyRead();
    testTiedLow();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule